// File: doc/BRIEF.md
# Interrupt Domain Register Interface

This block decodes the 32-bit memory-mapped register window of an interrupt domain. Each request is one read or write of a single word. The block turns the request into one-cycle strobes toward the source gateway and the dispatcher, and it builds read data from the state vectors that those neighbours expose. Per-source behaviour is not kept here: pending, enable, rectified input, source configuration and target all live in the neighbours. The block holds only two items of domain-wide state: the interrupt-enable flag and the last message-generation word.

Bitmap writes touch only the sources whose bit is 1. Writes by source number touch one source. A second set-pending-by-number register takes its value byte-swapped. Some registers read back something other than what was written: the clear-pending words return rectified input levels, and the clear-enable and by-number registers return zero. Every request gets a response one cycle later with a status code. An access that is not supported and an offset that is not mapped give different codes.

Top module: `irq_regif`

## Requirements
- R1: Only a request with `req_bytes`=4 and `req_addr[1:0]`=0 is accepted. Any other request answers with `rsp_err`=1, and it raises no strobe and changes no state. Every request gets `rsp_valid` in the next cycle, and its strobes appear in that same cycle.
- R2: An aligned word access to an offset that no register occupies answers with `rsp_err`=2 and `rsp_rdata`=0. It raises no strobe. A good access answers with `rsp_err`=0.
- R3: The domain word is at offset 0x0000. A write stores only bit 8 as the enable, which drives `domain_ie`. A read returns 0x8000_0004 with bit 8 set to the stored enable.
- R4: The source configuration word at 0x0004+4k, for k in 0..N-2, belongs to source k+1. A read returns that source's `CFG_W`-bit field, zero-extended. A write pulses `cfg_wr_en` with the source number and the raw write data.
- R5: The target word at 0x3004+4k, for k in 0..N-2, belongs to source k+1. A read returns that source's 32-bit target. A write pulses `tgt_wr_en` with the source number and the raw write data.
- R6: Writes to the bitmap words go to set-pending 0x1C00+4w, clear-pending 0x1D00+4w, set-enable 0x1E00+4w and clear-enable 0x1F00+4w. In word w, bit i stands for source 32w+i. Only bits that are 1 raise the matching mask bit. Source 0 and sources at or above N never get a mask bit.
- R7: Reading the set-pending words gives the pending bits, the clear-pending words give the rectified inputs, the set-enable words give the enable bits, and the clear-enable words give zero. The bit for source 0 and the bits past the last source read as zero.
- R8: The by-number registers read as zero. They are set-pending 0x1CDC, clear-pending 0x1DDC, set-enable 0x1EDC, clear-enable 0x1FDC and little-endian set-pending 0x2000. A write raises the mask bit of the one source whose number equals the written value. A value of 0 or a value of N or more raises nothing.
- R9: A write to the big-endian set-pending register at 0x2004 swaps the four bytes of the data and then acts as R8 set-pending. The register reads as zero.
- R10: A write to the message-generation word at 0x3000 stores the data with bits 17:12 cleared, and pulses `msi_req` with that cleared value on `msi_data`. A read returns the stored word.
- R11: There are ceil(N/32) bitmap words, where N counts source 0. The offset one word past the last bitmap word is unmapped, and so is the offset one word past source N-1 in the configuration and target arrays.
- R12: After reset `domain_ie` is 0, the stored message word is 0, and `rsp_valid`, every strobe and every mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset in the window |
| req_bytes | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 2 | 0 ok, 1 unsupported access, 2 unmapped offset |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| domain_ie | output | 1 | Domain interrupt enable |
| src_cfg_vec | input | NUM_SRC*CFG_W | Configuration field of each source, source s at s*CFG_W |
| tgt_vec | input | NUM_SRC*32 | Target word of each source, source s at s*32 |
| pend_vec | input | NUM_SRC | Pending bit of each source |
| en_vec | input | NUM_SRC | Enable bit of each source |
| rect_vec | input | NUM_SRC | Rectified input level of each source |
| cfg_wr_en | output | 1 | Source configuration write strobe |
| cfg_wr_src | output | SRC_W | Source number for the configuration write |
| cfg_wr_data | output | 32 | Configuration write data |
| tgt_wr_en | output | 1 | Target write strobe |
| tgt_wr_src | output | SRC_W | Source number for the target write |
| tgt_wr_data | output | 32 | Target write data |
| pend_set_mask | output | NUM_SRC | Sources to mark pending |
| pend_clr_mask | output | NUM_SRC | Sources to clear pending |
| en_set_mask | output | NUM_SRC | Sources to enable |
| en_clr_mask | output | NUM_SRC | Sources to disable |
| msi_req | output | 1 | Message-generation strobe |
| msi_data | output | 32 | Message word with bits 17:12 cleared |

## Verification
The bitmap path is driven with sparse words, with an all-ones word in the partial last word, and with a word whose bit 0 is set. These show whether the bit-to-source mapping is right, whether sources past the end are trimmed, and whether source 0 is excluded. The read path uses state vectors that differ from one another and have bit 0 set. This separates which vector each array returns and confirms that bit 0 is masked. The by-number registers are written with 0, with the last source, with one past the last source, and with values that only select a source after the byte swap. This separates the range check from the byte order. The array edges and an off-by-one word past each array are read to pin down the k+1 offset rule and the word count.

// File: rtl/irq_regif_pkg.sv
// Shared types and the offset map for the interrupt domain register interface.
// Assumes a byte-addressed window of at most 16 KiB.
package irq_regif_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_DOMCFG, RG_SRCCFG, RG_SETIP, RG_SETIPNUM, RG_CLRIP,
        RG_CLRIPNUM, RG_SETIE, RG_SETIENUM, RG_CLRIE, RG_CLRIENUM,
        RG_NUM_LE, RG_NUM_BE, RG_GENMSI, RG_TARGET
    } region_e;

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_UNSUP    = 2'd1,
        RSP_UNMAPPED = 2'd2
    } rsp_e;

    localparam int unsigned OFF_DOMCFG   = 32'h0000;
    localparam int unsigned OFF_SRCCFG   = 32'h0004;
    localparam int unsigned OFF_SETIP    = 32'h1C00;
    localparam int unsigned OFF_SETIPNUM = 32'h1CDC;
    localparam int unsigned OFF_CLRIP    = 32'h1D00;
    localparam int unsigned OFF_CLRIPNUM = 32'h1DDC;
    localparam int unsigned OFF_SETIE    = 32'h1E00;
    localparam int unsigned OFF_SETIENUM = 32'h1EDC;
    localparam int unsigned OFF_CLRIE    = 32'h1F00;
    localparam int unsigned OFF_CLRIENUM = 32'h1FDC;
    localparam int unsigned OFF_NUM_LE   = 32'h2000;
    localparam int unsigned OFF_NUM_BE   = 32'h2004;
    localparam int unsigned OFF_GENMSI   = 32'h3000;
    localparam int unsigned OFF_TARGET   = 32'h3004;

    localparam logic [31:0] DOMCFG_FIXED   = 32'h8000_0004;
    localparam int          IE_BIT         = 8;
    localparam logic [31:0] MSI_GUEST_MASK = 32'h0003_F000;

endpackage

// File: rtl/irq_regif_decode.sv
// Address decoder: classifies one request offset into a register region and
// an index (bitmap word number, or source number for the per-source arrays),
// and picks the response status. Assumes NUM_SRC >= 2 and NWORDS <= 32.
module irq_regif_decode
    import irq_regif_pkg::*;
#(
    parameter int AW      = 14,
    parameter int NUM_SRC = 40,
    parameter int SRC_W   = 6,
    parameter int NWORDS  = 2
) (
    input  logic [AW-1:0]    addr,
    input  logic [2:0]       bytes,
    output region_e          rg,
    output logic [SRC_W-1:0] idx,
    output rsp_e             err
);
    localparam int unsigned ARR_SPAN = (NUM_SRC - 1) * 4;
    localparam int unsigned BM_SPAN  = NWORDS * 4;

    logic [31:0] off;

    // Region match and index extraction.
    always_comb begin
        off = 32'(addr);
        rg  = RG_NONE;
        idx = '0;
        if (off == OFF_DOMCFG) begin
            rg = RG_DOMCFG;
        end else if (off >= OFF_SRCCFG && off < OFF_SRCCFG + ARR_SPAN) begin
            rg  = RG_SRCCFG;
            idx = SRC_W'((off - OFF_SRCCFG) >> 2) + SRC_W'(1);
        end else if (off >= OFF_SETIP && off < OFF_SETIP + BM_SPAN) begin
            rg  = RG_SETIP;
            idx = SRC_W'((off - OFF_SETIP) >> 2);
        end else if (off == OFF_SETIPNUM) begin
            rg = RG_SETIPNUM;
        end else if (off >= OFF_CLRIP && off < OFF_CLRIP + BM_SPAN) begin
            rg  = RG_CLRIP;
            idx = SRC_W'((off - OFF_CLRIP) >> 2);
        end else if (off == OFF_CLRIPNUM) begin
            rg = RG_CLRIPNUM;
        end else if (off >= OFF_SETIE && off < OFF_SETIE + BM_SPAN) begin
            rg  = RG_SETIE;
            idx = SRC_W'((off - OFF_SETIE) >> 2);
        end else if (off == OFF_SETIENUM) begin
            rg = RG_SETIENUM;
        end else if (off >= OFF_CLRIE && off < OFF_CLRIE + BM_SPAN) begin
            rg  = RG_CLRIE;
            idx = SRC_W'((off - OFF_CLRIE) >> 2);
        end else if (off == OFF_CLRIENUM) begin
            rg = RG_CLRIENUM;
        end else if (off == OFF_NUM_LE) begin
            rg = RG_NUM_LE;
        end else if (off == OFF_NUM_BE) begin
            rg = RG_NUM_BE;
        end else if (off == OFF_GENMSI) begin
            rg = RG_GENMSI;
        end else if (off >= OFF_TARGET && off < OFF_TARGET + ARR_SPAN) begin
            rg  = RG_TARGET;
            idx = SRC_W'((off - OFF_TARGET) >> 2) + SRC_W'(1);
        end
    end

    // Status: size/alignment errors take precedence over unmapped offsets.
    always_comb begin
        if (bytes != 3'd4 || addr[1:0] != 2'b00) err = RSP_UNSUP;
        else if (rg == RG_NONE)                  err = RSP_UNMAPPED;
        else                                     err = RSP_OK;
    end
endmodule

// File: rtl/irq_regif_masks.sv
// Strobe-mask builder: turns an accepted bitmap-word or by-number write into
// per-source set/clear masks for pending and enable. Source 0 and numbers at
// or past NUM_SRC never produce a bit. Purely combinational.
module irq_regif_masks
    import irq_regif_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int SRC_W   = 6
) (
    input  logic               wr,
    input  region_e            rg,
    input  logic [SRC_W-1:0]   idx,
    input  logic [31:0]        wdata,
    output logic [NUM_SRC-1:0] pend_set,
    output logic [NUM_SRC-1:0] pend_clr,
    output logic [NUM_SRC-1:0] en_set,
    output logic [NUM_SRC-1:0] en_clr
);
    logic [31:0] num;

    // Source number: byte-swapped for the big-endian port.
    always_comb begin
        if (rg == RG_NUM_BE) num = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
        else                 num = wdata;
    end

    assign pend_set[0] = 1'b0;
    assign pend_clr[0] = 1'b0;
    assign en_set[0]   = 1'b0;
    assign en_clr[0]   = 1'b0;

    for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
        localparam int WI = s / 32;
        localparam int BI = s % 32;
        logic bit_w;
        logic bit_n;
        // Word hit with the source's bit set, or exact number match.
        assign bit_w = (32'(idx) == WI) && wdata[BI];
        assign bit_n = (num == 32'(s));
        assign pend_set[s] = wr && ((rg == RG_SETIP && bit_w) ||
                             ((rg == RG_SETIPNUM || rg == RG_NUM_LE || rg == RG_NUM_BE) && bit_n));
        assign pend_clr[s] = wr && ((rg == RG_CLRIP && bit_w) || (rg == RG_CLRIPNUM && bit_n));
        assign en_set[s]   = wr && ((rg == RG_SETIE && bit_w) || (rg == RG_SETIENUM && bit_n));
        assign en_clr[s]   = wr && ((rg == RG_CLRIE && bit_w) || (rg == RG_CLRIENUM && bit_n));
    end
endmodule

// File: rtl/irq_regif_rdmux.sv
// Read-data assembler: packs state vectors into 32-bit bitmap words (source 0
// and bits past the last source forced to zero) and selects per-source
// configuration and target words. Purely combinational.
module irq_regif_rdmux
    import irq_regif_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int SRC_W   = 6,
    parameter int NWORDS  = 2,
    parameter int CFG_W   = 11
) (
    input  region_e                    rg,
    input  logic [SRC_W-1:0]           idx,
    input  logic                       ie,
    input  logic [31:0]                genmsi,
    input  logic [NUM_SRC*CFG_W-1:0]   cfg_vec,
    input  logic [NUM_SRC*32-1:0]      tgt_vec,
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC-1:0]         en,
    input  logic [NUM_SRC-1:0]         rect,
    output logic [31:0]                rdata
);
    logic [31:0] pw [NWORDS];
    logic [31:0] ew [NWORDS];
    logic [31:0] rw [NWORDS];
    logic [31:0] pword, eword, rword, cword, tword;

    // Pack the state vectors into bitmap words, dropping source 0.
    always_comb begin
        for (int w = 0; w < NWORDS; w++) begin
            pw[w] = '0;
            ew[w] = '0;
            rw[w] = '0;
            for (int b = 0; b < 32; b++) begin
                if (w * 32 + b > 0 && w * 32 + b < NUM_SRC) begin
                    pw[w][b] = pend[w * 32 + b];
                    ew[w][b] = en[w * 32 + b];
                    rw[w][b] = rect[w * 32 + b];
                end
            end
        end
    end

    // Select the addressed bitmap word and per-source entries.
    always_comb begin
        pword = '0;
        eword = '0;
        rword = '0;
        cword = '0;
        tword = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (32'(idx) == w) begin
                pword = pw[w];
                eword = ew[w];
                rword = rw[w];
            end
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (32'(idx) == s) begin
                cword = 32'(cfg_vec[s * CFG_W +: CFG_W]);
                tword = tgt_vec[s * 32 +: 32];
            end
        end
    end

    // Region-dependent read value; unlisted regions read as zero.
    always_comb begin
        case (rg)
            RG_DOMCFG: rdata = DOMCFG_FIXED | (32'(ie) << IE_BIT);
            RG_SRCCFG: rdata = cword;
            RG_SETIP:  rdata = pword;
            RG_CLRIP:  rdata = rword;
            RG_SETIE:  rdata = eword;
            RG_GENMSI: rdata = genmsi;
            RG_TARGET: rdata = tword;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_regif.sv
// Interrupt domain register interface, top level. Accepts one word request per
// cycle and answers one cycle later. Write strobes and masks are registered,
// so they appear in the same cycle as the response. Holds only the domain
// enable and the message-generation word; all per-source state is external.
module irq_regif
    import irq_regif_pkg::*;
#(
    parameter int AW      = 14,
    parameter int NUM_SRC = 40,
    parameter int CFG_W   = 11,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int NWORDS = (NUM_SRC + 31) / 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [AW-1:0]            req_addr,
    input  logic [2:0]               req_bytes,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_err,
    output logic [31:0]              rsp_rdata,
    output logic                     domain_ie,
    input  logic [NUM_SRC*CFG_W-1:0] src_cfg_vec,
    input  logic [NUM_SRC*32-1:0]    tgt_vec,
    input  logic [NUM_SRC-1:0]       pend_vec,
    input  logic [NUM_SRC-1:0]       en_vec,
    input  logic [NUM_SRC-1:0]       rect_vec,
    output logic                     cfg_wr_en,
    output logic [SRC_W-1:0]         cfg_wr_src,
    output logic [31:0]              cfg_wr_data,
    output logic                     tgt_wr_en,
    output logic [SRC_W-1:0]         tgt_wr_src,
    output logic [31:0]              tgt_wr_data,
    output logic [NUM_SRC-1:0]       pend_set_mask,
    output logic [NUM_SRC-1:0]       pend_clr_mask,
    output logic [NUM_SRC-1:0]       en_set_mask,
    output logic [NUM_SRC-1:0]       en_clr_mask,
    output logic                     msi_req,
    output logic [31:0]              msi_data
);
    region_e            rg;
    rsp_e               err;
    logic [SRC_W-1:0]   idx;
    logic               go_wr, go_rd;
    logic [31:0]        rd_c, genmsi_q;
    logic [NUM_SRC-1:0] ps_c, pc_c, es_c, ec_c;

    irq_regif_decode #(.AW(AW), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .NWORDS(NWORDS)) u_dec (
        .addr(req_addr), .bytes(req_bytes), .rg(rg), .idx(idx), .err(err)
    );

    assign go_wr = req_valid && req_write && (err == RSP_OK);
    assign go_rd = req_valid && !req_write && (err == RSP_OK);

    irq_regif_masks #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_masks (
        .wr(go_wr), .rg(rg), .idx(idx), .wdata(req_wdata),
        .pend_set(ps_c), .pend_clr(pc_c), .en_set(es_c), .en_clr(ec_c)
    );

    irq_regif_rdmux #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .NWORDS(NWORDS), .CFG_W(CFG_W)) u_rd (
        .rg(rg), .idx(idx), .ie(domain_ie), .genmsi(genmsi_q),
        .cfg_vec(src_cfg_vec), .tgt_vec(tgt_vec),
        .pend(pend_vec), .en(en_vec), .rect(rect_vec), .rdata(rd_c)
    );

    // Response register: status and read data, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= RSP_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid ? err : RSP_OK;
            rsp_rdata <= go_rd ? rd_c : '0;
        end
    end

    // Strobe registers toward the gateway and dispatcher.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_wr_en     <= 1'b0;
            cfg_wr_src    <= '0;
            cfg_wr_data   <= '0;
            tgt_wr_en     <= 1'b0;
            tgt_wr_src    <= '0;
            tgt_wr_data   <= '0;
            pend_set_mask <= '0;
            pend_clr_mask <= '0;
            en_set_mask   <= '0;
            en_clr_mask   <= '0;
            msi_req       <= 1'b0;
            msi_data      <= '0;
        end else begin
            cfg_wr_en     <= go_wr && rg == RG_SRCCFG;
            cfg_wr_src    <= idx;
            cfg_wr_data   <= req_wdata;
            tgt_wr_en     <= go_wr && rg == RG_TARGET;
            tgt_wr_src    <= idx;
            tgt_wr_data   <= req_wdata;
            pend_set_mask <= ps_c;
            pend_clr_mask <= pc_c;
            en_set_mask   <= es_c;
            en_clr_mask   <= ec_c;
            msi_req       <= go_wr && rg == RG_GENMSI;
            msi_data      <= req_wdata & ~MSI_GUEST_MASK;
        end
    end

    // Domain-wide state: enable flag and the stored message word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            domain_ie <= 1'b0;
            genmsi_q  <= '0;
        end else begin
            if (go_wr && rg == RG_DOMCFG) domain_ie <= req_wdata[IE_BIT];
            if (go_wr && rg == RG_GENMSI) genmsi_q  <= req_wdata & ~MSI_GUEST_MASK;
        end
    end

    // R1: every request is answered in the following cycle.
    p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1, R2: an errored response carries no side-effect strobe.
    p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err != RSP_OK) |->
        (pend_set_mask == '0 && pend_clr_mask == '0 && en_set_mask == '0 &&
         en_clr_mask == '0 && !cfg_wr_en && !tgt_wr_en && !msi_req));

    // R2: errored responses return zero data.
    p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err != RSP_OK) |-> rsp_rdata == '0);

    // R3: the enable changes only through an accepted domain write.
    p_ie_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_wr && rg == RG_DOMCFG) |=> $stable(domain_ie));

    // R8: a by-number write touches at most one source in total.
    p_num_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (rg == RG_SETIPNUM || rg == RG_CLRIPNUM ||
         rg == RG_SETIENUM || rg == RG_CLRIENUM || rg == RG_NUM_LE || rg == RG_NUM_BE))
        |=> $onehot0({pend_set_mask, pend_clr_mask, en_set_mask, en_clr_mask}));

    // R10: the message strobe never carries guest-index bits.
    p_msi_guest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> (msi_data & MSI_GUEST_MASK) == '0);
endmodule

// File: tb/irq_regif_tb.sv
module irq_regif_tb;
    localparam int AW = 14, NS = 40, CW = 11, SW = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n, req_valid, req_write;
    logic [AW-1:0]   req_addr;
    logic [2:0]      req_bytes;
    logic [31:0]     req_wdata;
    logic            rsp_valid, domain_ie, cfg_wr_en, tgt_wr_en, msi_req;
    logic [1:0]      rsp_err;
    logic [31:0]     rsp_rdata, cfg_wr_data, tgt_wr_data, msi_data;
    logic [SW-1:0]   cfg_wr_src, tgt_wr_src;
    logic [NS*CW-1:0] src_cfg_vec;
    logic [NS*32-1:0] tgt_vec;
    logic [NS-1:0]   pend_vec, en_vec, rect_vec;
    logic [NS-1:0]   pend_set_mask, pend_clr_mask, en_set_mask, en_clr_mask;

    irq_regif #(.AW(AW), .NUM_SRC(NS), .CFG_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .domain_ie(domain_ie), .src_cfg_vec(src_cfg_vec), .tgt_vec(tgt_vec),
        .pend_vec(pend_vec), .en_vec(en_vec), .rect_vec(rect_vec),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_src(cfg_wr_src), .cfg_wr_data(cfg_wr_data),
        .tgt_wr_en(tgt_wr_en), .tgt_wr_src(tgt_wr_src), .tgt_wr_data(tgt_wr_data),
        .pend_set_mask(pend_set_mask), .pend_clr_mask(pend_clr_mask),
        .en_set_mask(en_set_mask), .en_clr_mask(en_clr_mask),
        .msi_req(msi_req), .msi_data(msi_data)
    );

    int n_run = 0, n_fail = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request; returns at the negedge where the registered outputs are valid.
    task automatic access(input logic wr, input logic [15:0] a, input logic [2:0] nb,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a[AW-1:0];
        req_bytes = nb; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [63:0] no_masks();
        return 64'(pend_set_mask | pend_clr_mask | en_set_mask | en_clr_mask);
    endfunction

    // Read vectors: address, size, expected status, expected data.
    localparam int NV = 20;
    localparam logic [15:0] V_ADDR [NV] = '{
        16'h0000, 16'h1C00, 16'h1C04, 16'h1C08, 16'h1D00, 16'h1D04, 16'h1E00,
        16'h1E04, 16'h1F00, 16'h1CDC, 16'h2004, 16'h0004, 16'h009C, 16'h00A0,
        16'h3004, 16'h309C, 16'h30A0, 16'h0002, 16'h0000, 16'h1000 };
    localparam logic [2:0] V_BYTES [NV] = '{
        3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4,
        3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd2, 3'd4 };
    localparam logic [1:0] V_ERR [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd2, 2'd1, 2'd1, 2'd2 };
    localparam logic [31:0] V_DATA [NV] = '{
        32'h8000_0004, 32'h8765_4320, 32'h0000_00C3, 32'h0,
        32'hFFFF_FFFE, 32'h0000_005A, 32'h0000_0002, 32'h0000_000F,
        32'h0, 32'h0, 32'h0, 32'h1, 32'd39, 32'h0,
        32'h1000_0001, 32'h1000_0027, 32'h0, 32'h0, 32'h0, 32'h0 };
    localparam string V_TAG [NV] = '{
        "R3 domain read", "R7 pend w0", "R7 pend w1", "R11 word past end",
        "R7 rect w0", "R7 rect w1", "R7 en w0", "R7 en w1", "R7 clrie zero",
        "R8 num reads zero", "R9 be reads zero", "R4 cfg first", "R4 cfg last",
        "R11 cfg past end", "R5 tgt first", "R5 tgt last", "R11 tgt past end",
        "R1 misaligned", "R1 short size", "R2 unmapped gap" };

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_bytes = 3'd4; req_wdata = '0;
        pend_vec = 40'hC3_8765_4321;
        rect_vec = 40'h5A_FFFF_FFFF;
        en_vec   = 40'h0F_0000_0003;
        for (int s = 0; s < NS; s++) begin
            src_cfg_vec[s*CW +: CW] = CW'(s);
            tgt_vec[s*32 +: 32]     = 32'h1000_0000 + 32'(s);
        end
        repeat (3) @(negedge clk);
        chk("R12 rsp_valid", 64'(rsp_valid), 0);
        chk("R12 domain_ie", 64'(domain_ie), 0);
        chk("R12 masks", no_masks(), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(1'b0, V_ADDR[i], V_BYTES[i], 32'h0);
            chk({V_TAG[i], " status"}, 64'(rsp_err), 64'(V_ERR[i]));
            chk({V_TAG[i], " data"}, 64'(rsp_rdata), 64'(V_DATA[i]));
        end

        access(1'b0, 16'h3000, 3'd4, 0);
        chk("R12 genmsi reset", 64'(rsp_rdata), 0);

        // R3 enable write and readback
        access(1'b1, 16'h0000, 3'd4, 32'hFFFF_FFFF);
        chk("R3 ie set", 64'(domain_ie), 1);
        access(1'b0, 16'h0000, 3'd4, 0);
        chk("R3 read with ie", 64'(rsp_rdata), 64'h8000_0104);
        access(1'b1, 16'h0000, 3'd4, 32'hFFFF_FEFF);
        chk("R3 ie clear", 64'(domain_ie), 0);

        // R6 bitmap writes
        access(1'b1, 16'h1C00, 3'd4, 32'h0000_0005);
        chk("R6 setip w0 src0 dropped", 64'(pend_set_mask), 64'h4);
        chk("R1 strobe with rsp", 64'(rsp_valid), 1);
        access(1'b1, 16'h1F04, 3'd4, 32'hFFFF_FFFF);
        chk("R6 clrie w1 trimmed", 64'(en_clr_mask), 64'hFF_0000_0000);
        access(1'b1, 16'h1E00, 3'd4, 32'h8000_0001);
        chk("R6 setie w0", 64'(en_set_mask), 64'h8000_0000);
        access(1'b1, 16'h1D04, 3'd4, 32'h0000_0081);
        chk("R6 clrip w1", 64'(pend_clr_mask), 64'h80_0000_0000 | 64'h01_0000_0000);

        // R8 by-number writes
        access(1'b1, 16'h1CDC, 3'd4, 32'd5);
        chk("R8 setipnum 5", 64'(pend_set_mask), 64'h20);
        access(1'b1, 16'h1DDC, 3'd4, 32'd39);
        chk("R8 clripnum last", 64'(pend_clr_mask), 64'h80_0000_0000);
        access(1'b1, 16'h1FDC, 3'd4, 32'd40);
        chk("R8 clrienum past end", no_masks(), 0);
        access(1'b1, 16'h1EDC, 3'd4, 32'd0);
        chk("R8 setienum zero", no_masks(), 0);
        access(1'b1, 16'h1EDC, 3'd4, 32'd33);
        chk("R8 setienum 33", 64'(en_set_mask), 64'h2_0000_0000);
        access(1'b1, 16'h2000, 3'd4, 32'd7);
        chk("R8 le num 7", 64'(pend_set_mask), 64'h80);

        // R9 big-endian port
        access(1'b1, 16'h2004, 3'd4, 32'h0900_0000);
        chk("R9 be swapped 9", 64'(pend_set_mask), 64'h200);
        access(1'b1, 16'h2004, 3'd4, 32'h0000_0009);
        chk("R9 be unswapped out of range", no_masks(), 0);

        // R10 message generation
        access(1'b1, 16'h3000, 3'd4, 32'hFFFF_FFFF);
        chk("R10 msi strobe", 64'(msi_req), 1);
        chk("R10 msi data", 64'(msi_data), 64'hFFFC_0FFF);
        access(1'b0, 16'h3000, 3'd4, 0);
        chk("R10 genmsi read", 64'(rsp_rdata), 64'hFFFC_0FFF);

        // R4/R5 write strobes
        access(1'b1, 16'h009C, 3'd4, 32'h0000_0405);
        chk("R4 cfg strobe", 64'(cfg_wr_en), 1);
        chk("R4 cfg src", 64'(cfg_wr_src), 39);
        chk("R4 cfg data", 64'(cfg_wr_data), 64'h405);
        access(1'b1, 16'h3004, 3'd4, 32'h0000_1234);
        chk("R5 tgt strobe", 64'(tgt_wr_en), 1);
        chk("R5 tgt src", 64'(tgt_wr_src), 1);
        chk("R5 tgt data", 64'(tgt_wr_data), 64'h1234);

        // R1/R2 rejected writes have no effect
        access(1'b1, 16'h1C01, 3'd4, 32'hFFFF_FFFF);
        chk("R1 misaligned write err", 64'(rsp_err), 1);
        chk("R1 misaligned write masks", no_masks(), 0);
        access(1'b1, 16'h3000, 3'd1, 32'h0000_0001);
        chk("R1 byte write no msi", 64'(msi_req), 0);
        access(1'b1, 16'h0000, 3'd2, 32'hFFFF_FFFF);
        chk("R1 short write ie kept", 64'(domain_ie), 0);
        access(1'b1, 16'h1C08, 3'd4, 32'hFFFF_FFFF);
        chk("R2 unmapped write err", 64'(rsp_err), 2);
        chk("R2 unmapped write masks", no_masks(), 0);
        access(1'b0, 16'h3000, 3'd4, 0);
        chk("R1 genmsi kept", 64'(rsp_rdata), 64'hFFFC_0FFF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule